// File: doc/BRIEF.md
# MD5 Block Compression Engine

This block runs the MD5 compression function over one 512-bit message block and adds the result into a 128-bit chaining state that it keeps between blocks. A separate block handles message padding and length appending and presents each finished 512-bit block on `msg`, with a one-cycle `start` strobe. Word w of the block is `msg[32w+31:32w]`, and byte k of the block is `msg[8k+7:8k]`, so the words are little-endian. The engine works through the 64 MD5 steps four at a time. Each group of four steps is one process cycle lasting `CLKS_PER_PC` clocks. All four round functions are computed side by side, and a set of 32-bit mask registers selects one of them.

A process cycle first reads its four additive constants in a single access. The constants come from two 32-entry banks, each with a read port for even addresses and one for odd addresses. The cycle then applies the four chained steps to the working words A, B, C and D on its last clock. After sixteen such cycles, a seventeenth adds the working words into the saved chaining words, and `done` pulses. The chaining state comes out on `state_out` with A in bits 31:0, B in 63:32, C in 95:64 and D in 127:96. Byte k of the MD5 digest is therefore `state_out[8k+7:8k]`.

The `init` input reloads the standard starting value when the engine is idle. Raising it together with `start` begins the block from that starting value. Without `init`, each new block continues from the previous result, which is how multi-block messages are hashed.

Top module: `md5_blk_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `state_out` equals the starting value: A=0x67452301 in bits 31:0, B=0xEFCDAB89 in 63:32, C=0x98BADCFE in 95:64, D=0x10325476 in 127:96.
- R2: A one-cycle `init` while idle, without `start`, sets `state_out` to the R1 starting value from the next cycle on.
- R3: For a block with word w at `msg[32w+31:32w]`, the value on `state_out` after `done` is the standard MD5 compression of that block into the previous chaining state. Byte k of the digest sits at `state_out[8k+7:8k]`, starting with the low byte of A.
- R4: `done` is high for exactly one cycle, in the 17*CLKS_PER_PC-th cycle after the edge that accepted `start` (68 with the default). `busy` is high from the cycle after that edge up to the cycle in which `done` rises, and it is low in that cycle.
- R5: `start` and `init` have no effect while `busy` is high: the result and its timing are unchanged, and no further block runs afterwards.
- R6: A `start` without `init` compresses into the chaining state left by the previous block.
- R7: When `init` and `start` are high in the same idle cycle, the block is compressed into the R1 starting value.
- R8: `state_out` stays constant while `busy` is high. It changes only in the cycle in which `done` rises.
- R9: In every process cycle, exactly one of the four 32-bit round masks is all ones and the other three are zero. Bits 3:2 of the process-cycle counter select the mask: 0 selects F, 1 selects G, 2 selects H and 3 selects I. All masks reset to zero.
- R10: The working words change only on the last clock of a process cycle. The four constants for a process cycle are read in one access: T0 and T1 come from the low bank's even and odd ports, and T2 and T3 from the high bank's even and odd ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Reload the starting chaining value (idle only) |
| start | input | 1 | Begin compressing `msg` (idle only) |
| msg | input | 512 | Message block, word w at bits 32w+31:32w |
| busy | output | 1 | Compression in progress |
| done | output | 1 | One-cycle pulse when `state_out` holds the new chaining value |
| state_out | output | 128 | Chaining state {D, C, B, A} |

## Verification
The bench builds the engine with `CLKS_PER_PC = 4`, the default, so each block takes 68 clocks. Its latency check is derived from the same localparam that it passes to the instance, so a build with the minimum of 2 clocks per process cycle is covered by changing one value. Expected digests come from published test strings and from a behavioural model in the bench that derives its constants from the sine function. The default timing leaves room to pulse `start` and `init` in the middle of a block, so the bench can check that these pulses are ignored and that `state_out` holds still while the block runs. Back-to-back blocks without `init` exercise the chaining path.

// File: rtl/md5_pkg.sv
package md5_pkg;

  localparam int WORD_W       = 32;
  localparam int BLK_WORDS    = 16;
  localparam int BLK_W        = WORD_W * BLK_WORDS;
  localparam int STATE_W      = 4 * WORD_W;
  localparam int TOTAL_STEPS  = 64;
  localparam int STEPS_PER_PC = 4;
  localparam int NUM_PC       = TOTAL_STEPS / STEPS_PER_PC;
  localparam int NUM_FN       = 4;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [STATE_W-1:0] state_t;

  localparam word_t IV_A = 32'h67452301;
  localparam word_t IV_B = 32'hEFCDAB89;
  localparam word_t IV_C = 32'h98BADCFE;
  localparam word_t IV_D = 32'h10325476;
  localparam state_t IV_STATE = {IV_D, IV_C, IV_B, IV_A};

  function automatic word_t rotl(input word_t x, input logic [4:0] s);
    logic [2*WORD_W-1:0] dbl;
    dbl = {x, x} << s;
    return dbl[2*WORD_W-1:WORD_W];
  endfunction

  function automatic word_t fn_f(input word_t b, input word_t c, input word_t d);
    return (b & c) | (~b & d);
  endfunction

  function automatic word_t fn_g(input word_t b, input word_t c, input word_t d);
    return (b & d) | (c & ~d);
  endfunction

  function automatic word_t fn_h(input word_t b, input word_t c, input word_t d);
    return b ^ c ^ d;
  endfunction

  function automatic word_t fn_i(input word_t b, input word_t c, input word_t d);
    return c ^ (b | ~d);
  endfunction

  function automatic logic [4:0] shift_amt(input logic [1:0] rnd, input logic [1:0] k);
    logic [4:0] s;
    case ({rnd, k})
      4'h0: s = 5'd7;   4'h1: s = 5'd12;  4'h2: s = 5'd17;  4'h3: s = 5'd22;
      4'h4: s = 5'd5;   4'h5: s = 5'd9;   4'h6: s = 5'd14;  4'h7: s = 5'd20;
      4'h8: s = 5'd4;   4'h9: s = 5'd11;  4'hA: s = 5'd16;  4'hB: s = 5'd23;
      default: begin
        case (k)
          2'd0: s = 5'd6;
          2'd1: s = 5'd10;
          2'd2: s = 5'd15;
          default: s = 5'd21;
        endcase
      end
    endcase
    return s;
  endfunction

  function automatic logic [3:0] msg_index(input logic [5:0] j);
    logic [3:0] i;
    logic [3:0] r;
    i = j[3:0];
    case (j[5:4])
      2'd0: r = i;
      2'd1: r = (i * 4'd5) + 4'd1;
      2'd2: r = (i * 4'd3) + 4'd5;
      default: r = i * 4'd7;
    endcase
    return r;
  endfunction

  function automatic word_t round_const(input logic [5:0] j);
    word_t t;
    case (j)
      6'd0:  t = 32'hd76aa478; 6'd1:  t = 32'he8c7b756; 6'd2:  t = 32'h242070db; 6'd3:  t = 32'hc1bdceee;
      6'd4:  t = 32'hf57c0faf; 6'd5:  t = 32'h4787c62a; 6'd6:  t = 32'ha8304613; 6'd7:  t = 32'hfd469501;
      6'd8:  t = 32'h698098d8; 6'd9:  t = 32'h8b44f7af; 6'd10: t = 32'hffff5bb1; 6'd11: t = 32'h895cd7be;
      6'd12: t = 32'h6b901122; 6'd13: t = 32'hfd987193; 6'd14: t = 32'ha679438e; 6'd15: t = 32'h49b40821;
      6'd16: t = 32'hf61e2562; 6'd17: t = 32'hc040b340; 6'd18: t = 32'h265e5a51; 6'd19: t = 32'he9b6c7aa;
      6'd20: t = 32'hd62f105d; 6'd21: t = 32'h02441453; 6'd22: t = 32'hd8a1e681; 6'd23: t = 32'he7d3fbc8;
      6'd24: t = 32'h21e1cde6; 6'd25: t = 32'hc33707d6; 6'd26: t = 32'hf4d50d87; 6'd27: t = 32'h455a14ed;
      6'd28: t = 32'ha9e3e905; 6'd29: t = 32'hfcefa3f8; 6'd30: t = 32'h676f02d9; 6'd31: t = 32'h8d2a4c8a;
      6'd32: t = 32'hfffa3942; 6'd33: t = 32'h8771f681; 6'd34: t = 32'h6d9d6122; 6'd35: t = 32'hfde5380c;
      6'd36: t = 32'ha4beea44; 6'd37: t = 32'h4bdecfa9; 6'd38: t = 32'hf6bb4b60; 6'd39: t = 32'hbebfbc70;
      6'd40: t = 32'h289b7ec6; 6'd41: t = 32'heaa127fa; 6'd42: t = 32'hd4ef3085; 6'd43: t = 32'h04881d05;
      6'd44: t = 32'hd9d4d039; 6'd45: t = 32'he6db99e5; 6'd46: t = 32'h1fa27cf8; 6'd47: t = 32'hc4ac5665;
      6'd48: t = 32'hf4292244; 6'd49: t = 32'h432aff97; 6'd50: t = 32'hab9423a7; 6'd51: t = 32'hfc93a039;
      6'd52: t = 32'h655b59c3; 6'd53: t = 32'h8f0ccc92; 6'd54: t = 32'hffeff47d; 6'd55: t = 32'h85845dd1;
      6'd56: t = 32'h6fa87e4f; 6'd57: t = 32'hfe2ce6e0; 6'd58: t = 32'ha3014314; 6'd59: t = 32'h4e0811a1;
      6'd60: t = 32'hf7537e82; 6'd61: t = 32'hbd3af235; 6'd62: t = 32'h2ad7d2bb; default: t = 32'heb86d391;
    endcase
    return t;
  endfunction

  // One MD5 step on a packed {d, c, b, a} state with an already selected round function value.
  function automatic state_t md5_step(input state_t st, input word_t fsel, input word_t kc,
                                      input word_t m, input logic [4:0] sh);
    word_t a, b, c, d, sum;
    {d, c, b, a} = st;
    sum = a + fsel + kc + m;
    return {c, b, b + rotl(sum, sh), d};
  endfunction

  function automatic state_t state_add(input state_t x, input state_t y);
    state_t r;
    for (int w = 0; w < 4; w++) begin
      r[w*WORD_W +: WORD_W] = x[w*WORD_W +: WORD_W] + y[w*WORD_W +: WORD_W];
    end
    return r;
  endfunction

endpackage

// File: rtl/md5_kbank.sv
module md5_kbank
  import md5_pkg::*;
#(
  parameter bit HIGH  = 1'b0,
  parameter int DEPTH = 2 * NUM_PC,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] addr_even,
  input  logic [AW-1:0] addr_odd,
  output word_t         q_even,
  output word_t         q_odd
);

  word_t rom [DEPTH];

  // Entry a holds the constant of step 4*(a/2) + 2*HIGH + (a%2).
  for (genvar a = 0; a < DEPTH; a++) begin : g_fill
    localparam logic [5:0] STEP = 6'((a / 2) * 4 + (HIGH ? 2 : 0) + (a % 2));
    assign rom[a] = round_const(STEP);
  end

  always_ff @(posedge clk) begin
    if (rd_en) q_even <= rom[addr_even];
  end

  always_ff @(posedge clk) begin
    if (rd_en) q_odd <= rom[addr_odd];
  end

  // R10: each port only ever serves its own address parity
  p_port_parity_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (!addr_even[0] && addr_odd[0]));

endmodule

// File: rtl/md5_round_mask.sv
module md5_round_mask
  import md5_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [1:0]               rnd,
  output logic [NUM_FN-1:0][WORD_W-1:0] masks
);

  logic [NUM_FN-1:0] mask_full;
  logic [NUM_FN-1:0] mask_any;

  for (genvar f = 0; f < NUM_FN; f++) begin : g_mask
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    masks[f] <= '0;
      else if (load) masks[f] <= (rnd == 2'(f)) ? '1 : '0;
    end
    assign mask_full[f] = &masks[f];
    assign mask_any[f]  = |masks[f];
  end

  // R9: after a load exactly one mask is all ones and the others are clear
  p_one_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ($countones(mask_full) == 1 && $countones(mask_any) == 1));

  // R9: masks move only on a load
  p_mask_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(masks));

endmodule

// File: rtl/md5_step_chain.sv
module md5_step_chain
  import md5_pkg::*;
(
  input  state_t                         work,
  input  logic [NUM_FN-1:0][WORD_W-1:0]  masks,
  input  logic [STEPS_PER_PC-1:0][WORD_W-1:0] kvec,
  input  logic [BLK_W-1:0]               msg,
  input  logic [3:0]                     pc,
  output state_t                         nxt
);

  always_comb begin
    state_t     st;
    word_t      b, c, d, fsel, mw;
    logic [5:0] j;
    st = work;
    for (int k = 0; k < STEPS_PER_PC; k++) begin
      b    = st[1*WORD_W +: WORD_W];
      c    = st[2*WORD_W +: WORD_W];
      d    = st[3*WORD_W +: WORD_W];
      j    = {pc, 2'(k)};
      fsel = (fn_f(b, c, d) & masks[0]) | (fn_g(b, c, d) & masks[1])
           | (fn_h(b, c, d) & masks[2]) | (fn_i(b, c, d) & masks[3]);
      mw   = msg[WORD_W * msg_index(j) +: WORD_W];
      st   = md5_step(st, fsel, kvec[k], mw, shift_amt(pc[3:2], 2'(k)));
    end
    nxt = st;
  end

endmodule

// File: rtl/md5_blk_engine.sv
module md5_blk_engine
  import md5_pkg::*;
#(
  parameter int CLKS_PER_PC = 4,
  localparam int PH_W       = (CLKS_PER_PC > 2) ? $clog2(CLKS_PER_PC) : 1,
  localparam int PC_W       = $clog2(NUM_PC) + 1,
  localparam int KDEPTH     = 2 * NUM_PC,
  localparam int KAW        = $clog2(KDEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic               start,
  input  logic [BLK_W-1:0]   msg,
  output logic               busy,
  output logic               done,
  output logic [STATE_W-1:0] state_out
);

  logic              active;
  logic [PC_W-1:0]   pc;
  logic [PH_W-1:0]   ph;
  state_t            chain;
  state_t            work;
  state_t            nxt;
  logic [BLK_W-1:0]  msg_q;
  logic              done_q;

  // Named events
  logic   accept_start, accept_init;
  logic   ph_first, ph_last, in_compress;
  logic   fetch_en, work_upd, finish;
  state_t base;

  assign accept_start = start && !active;
  assign accept_init  = init && !active;
  assign ph_first     = active && (ph == '0);
  assign ph_last      = active && (ph == PH_W'(CLKS_PER_PC - 1));
  assign in_compress  = (pc < PC_W'(NUM_PC));
  assign fetch_en     = ph_first && in_compress;
  assign work_upd     = ph_last && in_compress;
  assign finish       = ph_last && !in_compress;
  assign base         = accept_init ? IV_STATE : chain;

  // Constant fetch: low bank gives T0/T1, high bank T2/T3
  logic [KAW-1:0] k_addr_even, k_addr_odd;
  logic [STEPS_PER_PC-1:0][WORD_W-1:0] kvec;
  assign k_addr_even = {pc[PC_W-2:0], 1'b0};
  assign k_addr_odd  = {pc[PC_W-2:0], 1'b1};

  for (genvar bk = 0; bk < 2; bk++) begin : g_bank
    md5_kbank #(.HIGH(bk[0]), .DEPTH(KDEPTH)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (fetch_en),
      .addr_even (k_addr_even),
      .addr_odd  (k_addr_odd),
      .q_even    (kvec[2*bk]),
      .q_odd     (kvec[2*bk+1])
    );
  end

  logic [NUM_FN-1:0][WORD_W-1:0] masks;
  md5_round_mask u_mask (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fetch_en),
    .rnd   (pc[3:2]),
    .masks (masks)
  );

  md5_step_chain u_chain (
    .work  (work),
    .masks (masks),
    .kvec  (kvec),
    .msg   (msg_q),
    .pc    (pc[3:0]),
    .nxt   (nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      pc     <= '0;
      ph     <= '0;
      chain  <= IV_STATE;
      work   <= '0;
      msg_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (accept_start) begin
        active <= 1'b1;
        pc     <= '0;
        ph     <= '0;
        msg_q  <= msg;
        work   <= base;
        chain  <= base;
      end else if (accept_init) begin
        chain <= IV_STATE;
      end else if (active) begin
        ph <= ph_last ? '0 : ph + 1'b1;
        if (ph_last)  pc   <= pc + 1'b1;
        if (work_upd) work <= nxt;
        if (finish) begin
          chain  <= state_add(chain, work);
          active <= 1'b0;
        end
      end
    end
  end

  assign busy      = active;
  assign done      = done_q;
  assign state_out = chain;

  // R4: done lasts one cycle
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R4: busy falls exactly when done rises, never together
  p_busy_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R8: visible chaining state frozen while a block runs
  p_state_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (done || $stable(state_out)));

  // R10: working words move only at a process-cycle boundary
  p_work_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !ph_last) |=> $stable(work));

  // R4: process-cycle counter never passes the finishing cycle
  p_pc_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (pc <= PC_W'(NUM_PC)));

endmodule

// File: tb/sim_md5_blk_engine.sv
module sim_md5_blk_engine;

  localparam int CLK_PERIOD = 10;
  localparam int CPC        = 4;
  localparam int LAT        = 17 * CPC;
  localparam int WATCHDOG   = 20000;
  localparam logic [127:0] IV = {32'h10325476, 32'h98BADCFE, 32'hEFCDAB89, 32'h67452301};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         init = 1'b0;
  logic         start = 1'b0;
  logic [511:0] msg = '0;
  logic         busy, done;
  logic [127:0] state_out;

  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;

  typedef struct {
    logic [127:0] v;
    string        tag;
    longint       c0;
  } item_t;
  item_t exp_q[$];

  bit [31:0] kt [64];

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  md5_blk_engine #(.CLKS_PER_PC(CPC)) u0 (
    .clk(clk), .rst_n(rst_n), .init(init), .start(start), .msg(msg),
    .busy(busy), .done(done), .state_out(state_out)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
    end
  endtask

  function automatic logic [127:0] bswap128(input logic [127:0] x);
    logic [127:0] r;
    for (int k = 0; k < 16; k++) r[8*k +: 8] = x[8*(15-k) +: 8];
    return r;
  endfunction

  function automatic logic [511:0] pad_msg(input string s);
    logic [511:0] m;
    m = '0;
    for (int k = 0; k < s.len(); k++) m[8*k +: 8] = s[k];
    m[8*s.len() +: 8] = 8'h80;
    m[448 +: 64] = 64'(s.len() * 8);
    return m;
  endfunction

  function automatic bit [31:0] rol(input bit [31:0] x, input int s);
    return (x << s) | (x >> (32 - s));
  endfunction

  // Behavioural compression written as a plain 64-iteration loop
  function automatic logic [127:0] ref_compress(input logic [127:0] st, input logic [511:0] m);
    int sh [4][4] = '{'{7, 12, 17, 22}, '{5, 9, 14, 20}, '{4, 11, 16, 23}, '{6, 10, 15, 21}};
    bit [31:0] a, b, c, d, f, t, w [16];
    int g;
    for (int i = 0; i < 16; i++) w[i] = m[32*i +: 32];
    a = st[31:0]; b = st[63:32]; c = st[95:64]; d = st[127:96];
    for (int i = 0; i < 64; i++) begin
      if (i < 16)      begin f = (b & c) | (~b & d); g = i;                end
      else if (i < 32) begin f = (d & b) | (~d & c); g = (5 * i + 1) % 16; end
      else if (i < 48) begin f = b ^ c ^ d;          g = (3 * i + 5) % 16; end
      else             begin f = c ^ (b | ~d);       g = (7 * i) % 16;     end
      t = a + f + kt[i] + w[g];
      a = d; d = c; c = b;
      b = b + rol(t, sh[i / 16][i % 4]);
    end
    return {st[127:96] + d, st[95:64] + c, st[63:32] + b, st[31:0] + a};
  endfunction

  task automatic run_block(input logic [511:0] m, input logic with_init,
                           input logic [127:0] expv, input string tag, input bit disturb);
    logic [127:0] held;
    item_t it;
    @(negedge clk);
    msg = m; start = 1'b1; init = with_init;
    it.v = expv; it.tag = tag; it.c0 = cyc + 1;
    exp_q.push_back(it);
    @(negedge clk);
    start = 1'b0; init = 1'b0;
    if (disturb) begin
      repeat (20) @(negedge clk);
      held = state_out;
      msg = ~m; start = 1'b1; init = 1'b1;
      @(negedge clk);
      start = 1'b0; init = 1'b0;
      check(busy === 1'b1, "R5", "busy kept through start/init pulse", 128'(busy), 128'd1);
      @(negedge clk);
      check(state_out === held, "R8", "state_out stable mid-block", state_out, held);
    end
    while (busy) @(negedge clk);
    @(negedge clk);
    check(done === 1'b0, "R4", "done single cycle", 128'(done), 128'd0);
  endtask

  // Monitor: pops the scoreboard whenever done is seen
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (done === 1'b1) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5", "done without pending block", state_out, '0);
        end else begin
          it = exp_q.pop_front();
          check(state_out === it.v, "R3 R9 R10", it.tag, state_out, it.v);
          check((cyc - it.c0) == LAT, "R4", "latency", 128'(cyc - it.c0), 128'(LAT));
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] e_a, e_x, e_y;
    logic [511:0] blk_x, blk_y;
    real v;
    for (int i = 0; i < 64; i++) begin
      v = $sin(real'(i + 1));
      if (v < 0.0) v = -v;
      kt[i] = 32'(longint'($floor(v * 4294967296.0)));
    end
    for (int k = 0; k < 64; k++) begin
      blk_x[8*k +: 8] = 8'(k * 7 + 3);
      blk_y[8*k +: 8] = 8'hA5 ^ 8'(k);
    end

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R1", "busy after reset", 128'(busy), 128'd0);
    check(done === 1'b0, "R1", "done after reset", 128'(done), 128'd0);
    check(state_out === IV, "R1", "state after reset", state_out, IV);

    // R3: empty string from the reset chaining value
    run_block(pad_msg(""), 1'b0, bswap128(128'hd41d8cd98f00b204e9800998ecf8427e), "R3 empty", 1'b0);

    // R7: init and start together restart from IV
    run_block(pad_msg("abc"), 1'b1, bswap128(128'h900150983cd24fb0d6963f7d28e17f72), "R7 abc", 1'b0);

    // R2: init alone while idle
    @(negedge clk); init = 1'b1;
    @(negedge clk); init = 1'b0;
    check(state_out === IV, "R2", "init reload", state_out, IV);
    check(busy === 1'b0, "R2", "init starts nothing", 128'(busy), 128'd0);

    run_block(pad_msg("message digest"), 1'b0,
              bswap128(128'hf96b697d7cb7938d525a2f31aaf161d0), "R3 message digest", 1'b0);

    // R5 R8: pulses during a block are ignored
    e_a = ref_compress(IV, pad_msg("a"));
    run_block(pad_msg("a"), 1'b1, e_a, "R5 a with disturbance", 1'b1);
    repeat (5) @(negedge clk);
    check(busy === 1'b0, "R5", "no extra block", 128'(busy), 128'd0);
    check(state_out === e_a, "R5", "ignored init left state", state_out, e_a);

    // R6: two chained blocks
    e_x = ref_compress(IV, blk_x);
    e_y = ref_compress(e_x, blk_y);
    run_block(blk_x, 1'b1, e_x, "R6 first block", 1'b0);
    run_block(blk_y, 1'b0, e_y, "R6 chained block", 1'b0);

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4", "all results seen", 128'(exp_q.size()), 128'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule